// File: doc/BRIEF.md
# Four-Channel Conversion Start Sequencer

This block is the control logic of a four-channel converter. Software writes one control register to set per-channel start requests, a flush command, an enable and a DMA grouping choice. The block holds those requests and sends them one per cycle, lowest channel number first, to a conversion pipeline with a fixed latency. Each start request clears itself in the cycle its conversion is launched.

A flush command sends a one-cycle abort to the pipeline. Conversions already in the pipeline are lost. Requests that have not been launched yet stay pending and go out once the flush cycle is over.

The pipeline reports each finished conversion with a done pulse and the channel number. The block turns each done pulse into a per-channel DMA request strobe. It also ORs a selectable low group of channels into one combined strobe. A second register holds five plain configuration bits, and its upper three bits are reserved.

Top module: `conv_start_seq`

## Requirements
- R1: After reset every register bit is 0. Register A (address 0) has this layout: bit 0 is enable, bit 1 is flush, bits 5:2 are the start bits for channels 0 to 3, and bits 7:6 are the DMA group select. No launch, flush or DMA strobe is active after reset.
- R2: A write of 1 to a start bit requests one conversion on that channel. The launch appears as launch_valid with launch_chan set to the channel number, in the cycle after the write at the earliest.
- R3: Start bits that are pending together are launched one per cycle, always the lowest-numbered pending channel first.
- R4: A start bit reads back as 1 until its conversion launches. It reads 0 from the cycle after the launch, unless it is written again.
- R5: A write with bit 1 set produces a pipe_flush pulse lasting exactly one cycle, in the next cycle. No launch happens during that pulse. Conversions in flight at the pulse never produce a done pulse or a DMA strobe. Bit 1 always reads back as 0.
- R6: Start requests that are still pending at a flush are kept, and they are launched after the flush cycle.
- R7: A done pulse for channel c gives dma_req bit c high for one cycle, in the next cycle. With the pipeline latency of 4 this is 5 cycles after the launch cycle.
- R8: The group select adds a combined strobe, dma_grp, which is the OR of the per-channel strobes in a group: 00 = none, 01 = channels 0 and 1, 10 = channels 0 to 2, 11 = channels 0 to 3.
- R9: While enable is 0, nothing is launched. Start bits written in that time stay pending and launch once enable is set.
- R10: Writing a start bit for a channel that is already pending merges with the existing request, so only one conversion is launched.
- R11: Register B (address 1) keeps bits 4:0 as written, and bits 7:5 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write select: 0 is register A, 1 is register B |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read select |
| rd_data | output | 8 | Read data for the selected register (combinational) |
| launch_valid | output | 1 | A conversion is sent to the pipeline this cycle |
| launch_chan | output | 2 | Channel of the launched conversion |
| pipe_flush | output | 1 | Abort pulse to the pipeline |
| done_valid | input | 1 | Pipeline completion pulse |
| done_chan | input | 2 | Channel of the completed conversion |
| dma_req | output | 4 | Per-channel DMA request strobes |
| dma_grp | output | 1 | Combined grouped DMA request strobe |

## Verification
A write lands at the clock edge and affects the next cycle. So the new read-back, the launch and the flush pulse are all due one cycle after the write, and a done pulse appears four cycles after its launch. The DMA strobes come one cycle after the done pulse, five cycles after the launch. The bench keeps a cycle-accurate reference model that it advances just after each rising edge and compares against the outputs at the following falling edge. Every result is therefore checked in exactly the cycle it is due, whether the stimulus is a random write sequence or one of the directed cases for flush, disable and merging.

// File: rtl/conv_start_seq.sv
module conv_start_seq #(
  parameter int NCH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_addr,
  output logic [7:0] rd_data,
  output logic       launch_valid,
  output logic [1:0] launch_chan,
  output logic       pipe_flush,
  input  logic       done_valid,
  input  logic [1:0] done_chan,
  output logic [3:0] dma_req,
  output logic       dma_grp
);
  localparam int CW = $clog2(NCH);

  logic           en_q, flush_q;
  logic [1:0]     grp_q;
  logic [NCH-1:0] pend_q, launch_mask, grp_mask, done_mask;
  logic [4:0]     cfgb_q;
  logic           wr_a, wr_b;

  assign wr_a = wr_en && !wr_addr;
  assign wr_b = wr_en && wr_addr;

  always_comb begin
    launch_chan = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (pend_q[i]) launch_chan = CW'(i);
  end

  assign launch_valid = en_q && (|pend_q) && !flush_q;
  assign launch_mask  = launch_valid ? (NCH'(1) << launch_chan) : '0;
  assign pipe_flush   = flush_q;
  assign done_mask    = done_valid ? (NCH'(1) << done_chan) : '0;

  always_comb begin
    case (grp_q)
      2'b00:   grp_mask = 4'b0000;
      2'b01:   grp_mask = 4'b0011;
      2'b10:   grp_mask = 4'b0111;
      default: grp_mask = 4'b1111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      flush_q <= 1'b0;
      grp_q   <= '0;
      pend_q  <= '0;
      cfgb_q  <= '0;
      dma_req <= '0;
      dma_grp <= 1'b0;
    end else begin
      pend_q  <= (pend_q & ~launch_mask) | (wr_a ? wr_data[5:2] : '0);
      flush_q <= wr_a && wr_data[1];
      if (wr_a) begin
        en_q  <= wr_data[0];
        grp_q <= wr_data[7:6];
      end
      if (wr_b) cfgb_q <= wr_data[4:0];
      dma_req <= done_mask;
      dma_grp <= |(done_mask & grp_mask);
    end
  end

  assign rd_data = rd_addr ? {3'b000, cfgb_q} : {grp_q, pend_q, 1'b0, en_q};

  p_launch_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid && !(wr_a && wr_data[2 + launch_chan]) |=> !pend_q[$past(launch_chan)]);
  p_flush_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_flush |-> $past(wr_a && wr_data[1]));
  p_flush_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_flush |-> !launch_valid);
  p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !launch_valid);
  p_dma_follows_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|dma_req) |-> $past(done_valid));
  p_dma_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dma_req));
  p_grp_needs_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_grp |-> (|dma_req));
  p_resv_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr |-> rd_data[7:5] == 3'b000);
endmodule

// File: tb/sim_conv_start_seq.sv
module sim_conv_start_seq;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic launch_valid, pipe_flush, dma_grp;
  logic [1:0] launch_chan;
  logic [3:0] dma_req;
  logic done_valid;
  logic [1:0] done_chan;

  always #5 clk = ~clk;

  conv_start_seq u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .launch_valid(launch_valid), .launch_chan(launch_chan), .pipe_flush(pipe_flush),
    .done_valid(done_valid), .done_chan(done_chan), .dma_req(dma_req), .dma_grp(dma_grp));

  // pipeline stub: latency 4, one per cycle, cleared by flush
  logic [3:0] sv;
  logic [1:0] sc [4];
  always_ff @(posedge clk) begin
    if (!rst_n || pipe_flush) sv <= '0;
    else begin
      sv <= {sv[2:0], launch_valid};
      sc[0] <= launch_chan; sc[1] <= sc[0]; sc[2] <= sc[1]; sc[3] <= sc[2];
    end
  end
  assign done_valid = sv[3];
  assign done_chan  = sc[3];

  int checks = 0, errors = 0, launches_seen [4];
  bit finished = 0;

  // reference model
  logic m_en, m_flush;
  logic [1:0] m_grp;
  logic [3:0] m_pend, m_dma, m_pv;
  logic [1:0] m_pc [4];
  logic [4:0] m_cfgb;
  logic m_dgrp;

  function automatic logic [3:0] gmask(logic [1:0] g);
    return g == 0 ? 4'b0000 : g == 1 ? 4'b0011 : g == 2 ? 4'b0111 : 4'b1111;
  endfunction
  function automatic logic [1:0] lowest(logic [3:0] p);
    for (int i = 0; i < 4; i++) if (p[i]) return 2'(i);
    return 0;
  endfunction
  function automatic logic m_launch();
    return m_en && (m_pend != 0) && !m_flush;
  endfunction

  task automatic model_reset();
    m_en = 0; m_flush = 0; m_grp = 0; m_pend = 0; m_dma = 0; m_pv = 0; m_cfgb = 0; m_dgrp = 0;
    for (int i = 0; i < 4; i++) m_pc[i] = 0;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [7:0] exp_rd;
    chk(launch_valid == m_launch(), "R2/R9 launch_valid", launch_valid, m_launch());
    if (m_launch()) chk(launch_chan == lowest(m_pend), "R3 launch_chan", launch_chan, lowest(m_pend));
    chk(pipe_flush == m_flush, "R5 pipe_flush", pipe_flush, m_flush);
    chk(dma_req == m_dma, "R7 dma_req", dma_req, m_dma);
    chk(dma_grp == m_dgrp, "R8 dma_grp", dma_grp, m_dgrp);
    exp_rd = rd_addr ? {3'b000, m_cfgb} : {m_grp, m_pend, 1'b0, m_en};
    chk(rd_data == exp_rd, rd_addr ? "R11 regB read" : "R4 regA read", rd_data, exp_rd);
    if (launch_valid) launches_seen[launch_chan]++;
  endtask

  task automatic model_step();
    logic l; logic [3:0] lm, dm;
    l = m_launch();
    lm = l ? 4'(1) << lowest(m_pend) : 4'b0;
    dm = m_pv[3] ? 4'(1) << m_pc[3] : 4'b0;
    m_dma = dm;
    m_dgrp = |(dm & gmask(m_grp));
    if (m_flush) m_pv = 0;
    else begin
      m_pv = {m_pv[2:0], l};
      m_pc[3] = m_pc[2]; m_pc[2] = m_pc[1]; m_pc[1] = m_pc[0]; m_pc[0] = lowest(m_pend);
    end
    m_pend = (m_pend & ~lm) | ((wr_en && !wr_addr) ? wr_data[5:2] : 4'b0);
    m_flush = wr_en && !wr_addr && wr_data[1];
    if (wr_en && !wr_addr) begin m_en = wr_data[0]; m_grp = wr_data[7:6]; end
    if (wr_en && wr_addr) m_cfgb = wr_data[4:0];
  endtask

  // one cycle: compare at negedge, drive, advance model after the edge
  task automatic cyc(bit we, bit wa, logic [7:0] wd, bit ra);
    @(negedge clk);
    rd_addr = ra;
    #1 compare();
    wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    #1 model_step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0);
  endtask

  initial begin
    int cnt;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(rd_data == 8'h00 && !launch_valid && !pipe_flush && dma_req == 0 && !dma_grp,
        "R1 reset outputs", rd_data, 0);
    rst_n = 1;
    idle(2);
    // R2/R3/R7/R8: sweep of all channels, group 10
    cyc(1, 0, 8'hBD, 0);
    idle(12);
    chk(launches_seen[0] == 1 && launches_seen[3] == 1, "R3 sweep launched all", launches_seen[3], 1);
    // R9: disabled starts stay pending
    cyc(1, 0, 8'h14, 0);
    idle(3);
    chk(rd_data[5:2] == 4'b0101 && !launch_valid, "R9 pending while disabled", rd_data, 8'h14);
    // R10: merge duplicate on ch2
    cnt = launches_seen[2];
    cyc(1, 0, 8'h10, 0);
    cyc(1, 0, 8'h11, 0);
    idle(10);
    chk(launches_seen[2] == cnt + 1, "R10 merged single launch", launches_seen[2], cnt + 1);
    // R5/R6: flush mid-sweep keeps pending, bit reads 0
    cyc(1, 0, 8'hFD, 0);
    cyc(1, 0, 8'hC3, 0);
    @(negedge clk);
    #1 chk(pipe_flush == 1 && rd_data[1] == 0, "R5 flush pulse and readback", pipe_flush, 1);
    idle(12);
    chk(u0.rd_data[5:2] == 0, "R6 pending drained after flush", rd_data[5:2], 0);
    // R11: reserved bits
    cyc(1, 1, 8'hFF, 1);
    @(negedge clk);
    #1 chk(rd_data == 8'h1F, "R11 reserved read zero", rd_data, 8'h1F);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if ($urandom_range(0, 7) != 0) d[1] = 0;
      if ($urandom_range(0, 5) != 0) d[0] = 1;
      if ($urandom_range(0, 2) == 0) cyc(1, 1'($urandom_range(0, 4) == 0), d, 1'($urandom));
      else cyc(0, 0, 8'h00, 1'($urandom));
    end
    idle(10);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule